// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates interrupt requests for a small processor core. It has a parameterised number of request lines and one non-maskable input. Each line carries a programmable priority byte. A group setting divides that byte into a preemption part and a sub-priority part. Three masking controls can hold the programmable lines back: a global mask, a fault mask and a base-priority threshold. The controller keeps pending state for every line, and software can force a line pending or clear it. It also holds a stack of the preemption levels that are currently active.

The core uses a handshake of three inputs. It starts exception entry on the vector that the controller offers. It fetches the vector once stacking is done. It signals a handler return at the end of the handler. During the stacking window the controller may swap the candidate for a more urgent arrival. On return it can chain straight into another pending handler, with no unstack and restack. Stacking itself and instruction execution stay in the core.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Only the top three bits of each 8-bit priority byte are stored. Readback on `prio_rd_o` shows those bits with bits [4:0] as zero, so a write of 0x5F reads back as 0x40. A lower value means more urgent.
- R2: The group value g (0..7) makes byte bits above position g the preemption part and the rest the sub-priority part. For g of 4 or less, all three stored bits are preemption, which gives 8 levels. For g = 5 there are 4 levels with 2 sub-levels each.
- R3: A request is offered on `req_valid_o` only when its preemption rank is strictly below (more urgent than) `cur_rank_o`. A request of equal or lower urgency stays pending.
- R4: Among the eligible pending lines, the controller selects the one with the smallest stored priority value, which orders them by preemption part and then by sub-priority. Ties go to the lowest line index.
- R5: A pending line whose preemption part equals the active level is not offered, even if its sub-priority is more urgent.
- R6: A line becomes pending when its `irq_i` bit is high or when `setpend_we` writes a 1 to its bit of `pend_wdata`. `clrpend_we` removes the pending state for bits written as 1, and a set wins over a clear in the same cycle. Acceptance of a line clears its pending bit. `pend_o` shows the pending state.
- R7: The non-maskable input uses vector number N_LINES (8 by default) and rank 0, which is above every line. No mask blocks it, and it cannot preempt itself.
- R8: While the global mask or the fault mask is set, no line is offered. A write to any mask register takes effect for arbitration from the next cycle onward.
- R9: The base threshold stores the top three bits of the value written. When it is nonzero, it blocks every line whose stored priority is greater than or equal to the threshold, so a write of 0xB0 blocks 0xA0, 0xC0 and 0xE0. A threshold of zero blocks nothing.
- R10: On `ret_i`, if the selected eligible request is more urgent than the level below the top of the stack, `tail_o` is high in that cycle. The top entry is then replaced by `req_vec_o` with no change in stack depth. Otherwise the top entry is popped.
- R11: While stacking is in progress, a request whose rank is strictly below the candidate's rank raises `late_o`. The candidate becomes that request from the next cycle. The displaced line stays pending.
- R12: `vec_fetch_i` pushes the candidate onto the active stack. `cur_rank_o` then reports the top entry's rank: 0 for the non-maskable input, preemption part plus 1 for a line, and 15 at thread level. `act_vec_o` reports the top entry's vector.
- R13: After reset, nothing is pending, the stack is empty (`cur_rank_o` = 15), all masks are clear and nothing is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | N_LINES | Request lines; a high level sets pending |
| nmi_i | input | 1 | Non-maskable request; a high level sets pending |
| prio_we | input | 1 | Priority byte write strobe |
| prio_idx | input | IDX_W | Line selected for the priority write |
| prio_wdata | input | 8 | Priority byte to write |
| prio_rd_idx | input | IDX_W | Line selected for priority readback |
| prio_rd_o | output | 8 | Priority byte readback |
| grp_we | input | 1 | Group setting write strobe |
| grp_wdata | input | 3 | Split position g |
| setpend_we | input | 1 | Force-pending strobe |
| clrpend_we | input | 1 | Clear-pending strobe |
| pend_wdata | input | N_LINES | Line mask for the set and clear strobes |
| pend_o | output | N_LINES | Pending state |
| gmask_we | input | 1 | Global mask write strobe |
| gmask_wdata | input | 1 | Global mask value |
| fmask_we | input | 1 | Fault mask write strobe |
| fmask_wdata | input | 1 | Fault mask value |
| bpri_we | input | 1 | Base threshold write strobe |
| bpri_wdata | input | 8 | Base threshold value |
| entry_start_i | input | 1 | Core begins stacking for the offered vector |
| vec_fetch_i | input | 1 | Core fetches the candidate vector |
| ret_i | input | 1 | Handler return |
| req_valid_o | output | 1 | An eligible preempting request is offered |
| req_vec_o | output | VEC_W | Selected vector |
| cand_vec_o | output | VEC_W | Vector being stacked for |
| late_o | output | 1 | Late-arrival swap in this cycle |
| tail_o | output | 1 | Tail-chain on this return |
| act_valid_o | output | 1 | Active stack not empty |
| act_vec_o | output | VEC_W | Vector of the top active entry |
| cur_rank_o | output | RANK_W | Current active rank |

## Verification
The checks assume that the core follows the handshake. It raises `entry_start_i` only while `req_valid_o` is high. It raises `vec_fetch_i` only during stacking. It raises `ret_i` only outside stacking with a handler active. The stimulus applies every core strobe for exactly one cycle and only in these states. The checks also assume that the group setting does not change while handlers are active, so the bench changes the group only at thread level.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_LINES   = 8,
  parameter int PRIO_BITS = 3,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int VEC_W  = $clog2(N_LINES + 1),
  localparam int RANK_W = $clog2(2**PRIO_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   irq_i,
  input  logic                 nmi_i,
  input  logic                 prio_we,
  input  logic [IDX_W-1:0]     prio_idx,
  input  logic [7:0]           prio_wdata,
  input  logic [IDX_W-1:0]     prio_rd_idx,
  output logic [7:0]           prio_rd_o,
  input  logic                 grp_we,
  input  logic [2:0]           grp_wdata,
  input  logic                 setpend_we,
  input  logic                 clrpend_we,
  input  logic [N_LINES-1:0]   pend_wdata,
  output logic [N_LINES-1:0]   pend_o,
  input  logic                 gmask_we,
  input  logic                 gmask_wdata,
  input  logic                 fmask_we,
  input  logic                 fmask_wdata,
  input  logic                 bpri_we,
  input  logic [7:0]           bpri_wdata,
  input  logic                 entry_start_i,
  input  logic                 vec_fetch_i,
  input  logic                 ret_i,
  output logic                 req_valid_o,
  output logic [VEC_W-1:0]     req_vec_o,
  output logic [VEC_W-1:0]     cand_vec_o,
  output logic                 late_o,
  output logic                 tail_o,
  output logic                 act_valid_o,
  output logic [VEC_W-1:0]     act_vec_o,
  output logic [RANK_W-1:0]    cur_rank_o
);
  localparam int LSB   = 8 - PRIO_BITS;
  localparam int DEPTH = 2**PRIO_BITS + 1;
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam logic [VEC_W-1:0]  NMI_VEC = VEC_W'(N_LINES);
  localparam logic [RANK_W-1:0] THREAD  = '1;

  logic [PRIO_BITS-1:0] prio_q [N_LINES];
  logic [2:0]           grp_q;
  logic                 gmask_q, fmask_q;
  logic [PRIO_BITS-1:0] bpri_q;
  logic [N_LINES-1:0]   pend_q;
  logic                 nmi_pend_q;
  logic                 stacking_q;
  logic [VEC_W-1:0]     cand_vec_q;
  logic [RANK_W-1:0]    cand_rank_q;
  logic [VEC_W-1:0]     stk_vec  [DEPTH];
  logic [RANK_W-1:0]    stk_rank [DEPTH];
  logic [SP_W-1:0]      sp;

  logic [PRIO_BITS-1:0] pmask;
  logic [N_LINES-1:0]   elig;
  logic                 best_ok;
  logic [IDX_W-1:0]     best_idx;
  logic [PRIO_BITS-1:0] best_p;
  logic                 sel_ok;
  logic [VEC_W-1:0]     sel_vec;
  logic [RANK_W-1:0]    sel_rank;
  logic [SP_W-1:0]      top_idx, below_idx;
  logic [RANK_W-1:0]    below_rank;
  logic                 do_start, do_fetch, do_ret;
  logic [N_LINES-1:0]   acc_clr;
  logic                 acc_nmi;

  always_comb
    for (int k = 0; k < PRIO_BITS; k++)
      pmask[k] = (LSB + k) > int'(grp_q);

  always_comb
    for (int i = 0; i < N_LINES; i++)
      elig[i] = pend_q[i] && !gmask_q && !fmask_q &&
                !((bpri_q != '0) && (prio_q[i] >= bpri_q));

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_p   = '1;
    for (int i = 0; i < N_LINES; i++)
      if (elig[i] && (!best_ok || prio_q[i] < best_p)) begin
        best_ok  = 1'b1;
        best_idx = IDX_W'(i);
        best_p   = prio_q[i];
      end
  end

  assign sel_ok   = nmi_pend_q || best_ok;
  assign sel_vec  = nmi_pend_q ? NMI_VEC : VEC_W'(best_idx);
  assign sel_rank = nmi_pend_q ? '0 : RANK_W'(best_p & pmask) + RANK_W'(1);

  assign top_idx    = sp - SP_W'(1);
  assign below_idx  = sp - SP_W'(2);
  assign cur_rank_o = (sp == '0) ? THREAD : stk_rank[top_idx];
  assign below_rank = (sp <= SP_W'(1)) ? THREAD : stk_rank[below_idx];
  assign act_valid_o = (sp != '0);
  assign act_vec_o   = (sp == '0) ? '0 : stk_vec[top_idx];

  assign req_valid_o = !stacking_q && sel_ok && (sel_rank < cur_rank_o);
  assign req_vec_o   = sel_vec;
  assign cand_vec_o  = cand_vec_q;
  assign late_o      = stacking_q && sel_ok && (sel_rank < cand_rank_q);

  assign do_start = entry_start_i && req_valid_o;
  assign do_fetch = vec_fetch_i && stacking_q;
  assign do_ret   = ret_i && !stacking_q && (sp != '0);
  assign tail_o   = do_ret && sel_ok && (sel_rank < below_rank);

  always_comb begin
    acc_clr = '0;
    acc_nmi = 1'b0;
    if (do_fetch) begin
      if (cand_vec_q == NMI_VEC) acc_nmi = 1'b1;
      else                       acc_clr[cand_vec_q[IDX_W-1:0]] = 1'b1;
    end else if (tail_o) begin
      if (sel_vec == NMI_VEC) acc_nmi = 1'b1;
      else                    acc_clr[sel_vec[IDX_W-1:0]] = 1'b1;
    end
  end

  assign pend_o    = pend_q;
  assign prio_rd_o = {prio_q[prio_rd_idx], {LSB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LINES; i++) prio_q[i] <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        stk_vec[d]  <= '0;
        stk_rank[d] <= '0;
      end
      grp_q       <= '0;
      gmask_q     <= 1'b0;
      fmask_q     <= 1'b0;
      bpri_q      <= '0;
      pend_q      <= '0;
      nmi_pend_q  <= 1'b0;
      stacking_q  <= 1'b0;
      cand_vec_q  <= '0;
      cand_rank_q <= '0;
      sp          <= '0;
    end else begin
      if (prio_we)  prio_q[prio_idx] <= prio_wdata[7:LSB];
      if (grp_we)   grp_q   <= grp_wdata;
      if (gmask_we) gmask_q <= gmask_wdata;
      if (fmask_we) fmask_q <= fmask_wdata;
      if (bpri_we)  bpri_q  <= bpri_wdata[7:LSB];

      pend_q <= (pend_q & ~acc_clr & ~(clrpend_we ? pend_wdata : '0))
              | irq_i | (setpend_we ? pend_wdata : '0);
      nmi_pend_q <= (nmi_pend_q && !acc_nmi) || nmi_i;

      if (do_start || late_o) begin
        cand_vec_q  <= sel_vec;
        cand_rank_q <= sel_rank;
      end
      if (do_start) stacking_q <= 1'b1;

      if (do_fetch) begin
        stk_vec[sp]  <= cand_vec_q;
        stk_rank[sp] <= cand_rank_q;
        sp           <= sp + SP_W'(1);
        stacking_q   <= 1'b0;
      end else if (do_ret) begin
        if (tail_o) begin
          stk_vec[top_idx]  <= sel_vec;
          stk_rank[top_idx] <= sel_rank;
        end else begin
          sp <= top_idx;
        end
      end
    end
  end
endmodule

module nest_irq_ctrl_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 4,
  parameter int RANK_W  = 4,
  parameter int SP_W    = 4,
  parameter int DEPTH   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stacking,
  input logic [SP_W-1:0]   sp,
  input logic              gmask,
  input logic              fmask,
  input logic              nmi_i,
  input logic              vec_fetch_i,
  input logic              req_valid_o,
  input logic [VEC_W-1:0]  req_vec_o,
  input logic              late_o,
  input logic              tail_o,
  input logic [VEC_W-1:0]  cand_vec_o,
  input logic              act_valid_o,
  input logic [RANK_W-1:0] cur_rank_o
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(N_LINES);

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));

  a_r3_fetch_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch_i && stacking) |=> (cur_rank_o < $past(cur_rank_o)));

  a_r7_nmi_offered: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nmi_i) && !stacking && cur_rank_o != '0) |-> (req_valid_o && req_vec_o == NMI_VEC));

  a_r8_masks_block_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ((gmask || fmask) && req_valid_o) |-> (req_vec_o == NMI_VEC));

  a_r10_tail_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    tail_o |=> (act_valid_o && sp == $past(sp)));

  a_r11_late_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |=> (cand_vec_o == $past(req_vec_o)));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
  .N_LINES(N_LINES), .VEC_W(VEC_W), .RANK_W(RANK_W), .SP_W(SP_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stacking(stacking_q), .sp(sp),
  .gmask(gmask_q), .fmask(fmask_q), .nmi_i(nmi_i), .vec_fetch_i(vec_fetch_i),
  .req_valid_o(req_valid_o), .req_vec_o(req_vec_o), .late_o(late_o),
  .tail_o(tail_o), .cand_vec_o(cand_vec_o), .act_valid_o(act_valid_o),
  .cur_rank_o(cur_rank_o)
);

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/100ps
module nest_irq_ctrl_bench;
  localparam int N = 8;
  localparam int O_RV = 0, O_RVEC = 1, O_LATE = 2, O_TAIL = 3, O_AVEC = 4,
                 O_AVAL = 5, O_RANK = 6, O_PEND = 7, O_PRD = 8, O_CAND = 9;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_i = '0, pend_wdata = '0;
  logic nmi_i = 0, prio_we = 0, grp_we = 0, setpend_we = 0, clrpend_we = 0;
  logic gmask_we = 0, gmask_wdata = 0, fmask_we = 0, fmask_wdata = 0, bpri_we = 0;
  logic entry_start_i = 0, vec_fetch_i = 0, ret_i = 0;
  logic [2:0] prio_idx = '0, prio_rd_idx = '0, grp_wdata = '0;
  logic [7:0] prio_wdata = '0, bpri_wdata = '0, prio_rd_o;
  logic [N-1:0] pend_o;
  logic req_valid_o, late_o, tail_o, act_valid_o;
  logic [3:0] req_vec_o, cand_vec_o, act_vec_o, cur_rank_o;

  nest_irq_ctrl u_nest_irq_ctrl (.*);

  always #2.5 clk = ~clk;

  typedef struct { int sel; int exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic int obs(int sel);
    case (sel)
      O_RV:   return int'(req_valid_o);
      O_RVEC: return int'(req_vec_o);
      O_LATE: return int'(late_o);
      O_TAIL: return int'(tail_o);
      O_AVEC: return int'(act_vec_o);
      O_AVAL: return int'(act_valid_o);
      O_RANK: return int'(cur_rank_o);
      O_PEND: return int'(pend_o);
      O_PRD:  return int'(prio_rd_o);
      default: return int'(cand_vec_o);
    endcase
  endfunction

  always @(negedge clk)
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = obs(it.sel);
      n_run++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: output %0d actual %0h expected %0h", it.tag, it.sel, act, it.exp);
      end
    end

  task automatic exp(int sel, int val, string tag);
    item_t it;
    it.sel = sel; it.exp = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    irq_i = '0; nmi_i = 0; prio_we = 0; grp_we = 0; setpend_we = 0; clrpend_we = 0;
    gmask_we = 0; fmask_we = 0; bpri_we = 0;
    entry_start_i = 0; vec_fetch_i = 0; ret_i = 0;
  endtask

  task automatic wr_prio(int idx, int val);
    prio_we = 1; prio_idx = 3'(idx); prio_wdata = 8'(val); tick();
  endtask

  task automatic setp(int m);
    setpend_we = 1; pend_wdata = N'(m); tick();
  endtask

  task automatic clrp(int m);
    clrpend_we = 1; pend_wdata = N'(m); tick();
  endtask

  task automatic take();
    entry_start_i = 1; tick();
    vec_fetch_i = 1; tick();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    exp(O_AVAL, 0, "R13"); exp(O_RV, 0, "R13"); exp(O_PEND, 0, "R13"); exp(O_RANK, 15, "R13");
    tick();

    wr_prio(0, 'hE0); wr_prio(1, 'h40); wr_prio(2, 'h40); wr_prio(3, 'h20);
    wr_prio(4, 'h60); wr_prio(5, 'h80); wr_prio(6, 'h5F); wr_prio(7, 'hA0);
    prio_rd_idx = 3'd6; exp(O_PRD, 'h40, "R1");
    tick();
    prio_rd_idx = 3'd0; exp(O_PRD, 'hE0, "R1");
    tick();

    // nested arbitration with all bits preemption (R2, R3, R4)
    setp('b0110);
    exp(O_RV, 1, "R4"); exp(O_RVEC, 1, "R4"); exp(O_PEND, 'h06, "R6");
    take();
    exp(O_AVEC, 1, "R12"); exp(O_RANK, 3, "R12"); exp(O_PEND, 'h04, "R6"); exp(O_RV, 0, "R3");
    setp('b1_0000);
    exp(O_RV, 0, "R3");
    setp('b1000);
    exp(O_RV, 1, "R3"); exp(O_RVEC, 3, "R3");
    take();
    exp(O_AVEC, 3, "R12"); exp(O_RANK, 2, "R2");
    ret_i = 1; exp(O_TAIL, 0, "R10");
    tick();
    exp(O_AVEC, 1, "R12"); exp(O_RANK, 3, "R12");
    ret_i = 1; exp(O_TAIL, 1, "R10"); exp(O_RVEC, 2, "R10");
    tick();
    exp(O_AVEC, 2, "R10"); exp(O_RANK, 3, "R10"); exp(O_PEND, 'h10, "R10");
    ret_i = 1; exp(O_TAIL, 1, "R10");
    tick();
    exp(O_AVEC, 4, "R10"); exp(O_RANK, 4, "R10");
    ret_i = 1; exp(O_TAIL, 0, "R10");
    tick();
    exp(O_AVAL, 0, "R12"); exp(O_RANK, 15, "R12");

    // group split at bit 5 (R2, R5)
    grp_we = 1; grp_wdata = 3'd5; tick();
    setp('b1_0000);
    take();
    exp(O_AVEC, 4, "R2"); exp(O_RANK, 3, "R2");
    setp('b0010);
    exp(O_RV, 0, "R5");
    setp('b1000);
    exp(O_RV, 1, "R2"); exp(O_RVEC, 3, "R2");
    clrp('b1000);
    exp(O_PEND, 'h02, "R6"); exp(O_RV, 0, "R6");
    ret_i = 1; exp(O_TAIL, 1, "R10"); exp(O_RVEC, 1, "R10");
    tick();
    ret_i = 1; exp(O_TAIL, 0, "R10");
    tick();
    wr_prio(5, 'hA0); wr_prio(7, 'h80);
    setp('b1010_0000);
    exp(O_RVEC, 7, "R4");
    take();
    exp(O_AVEC, 7, "R4"); exp(O_RANK, 5, "R2");
    ret_i = 1; exp(O_TAIL, 1, "R10"); exp(O_RVEC, 5, "R10");
    tick();
    exp(O_AVEC, 5, "R10"); exp(O_RANK, 5, "R2");
    ret_i = 1; tick();
    exp(O_AVAL, 0, "R12");
    grp_we = 1; grp_wdata = 3'd0; tick();

    // masks and the non-maskable input (R7, R8, R9)
    gmask_we = 1; gmask_wdata = 1; tick();
    setp('b1000);
    exp(O_RV, 0, "R8"); exp(O_PEND, 'h08, "R8");
    nmi_i = 1; tick();
    exp(O_RV, 1, "R7"); exp(O_RVEC, 8, "R7");
    take();
    exp(O_AVEC, 8, "R7"); exp(O_RANK, 0, "R7");
    nmi_i = 1; tick();
    exp(O_RV, 0, "R7");
    ret_i = 1; exp(O_TAIL, 1, "R7");
    tick();
    exp(O_AVEC, 8, "R7");
    ret_i = 1; exp(O_TAIL, 0, "R8");
    tick();
    gmask_we = 1; gmask_wdata = 0; exp(O_RV, 0, "R8");
    tick();
    exp(O_RV, 1, "R8"); exp(O_RVEC, 3, "R8");
    fmask_we = 1; fmask_wdata = 1; tick();
    exp(O_RV, 0, "R8");
    fmask_we = 1; fmask_wdata = 0; tick();
    bpri_we = 1; bpri_wdata = 'hB0; tick();
    clrp('b1000);
    setp('b0011_0001);
    exp(O_RV, 1, "R9"); exp(O_RVEC, 4, "R9");
    clrp('b0001_0000);
    exp(O_RV, 0, "R9"); exp(O_PEND, 'h21, "R9");
    bpri_we = 1; bpri_wdata = 'h00; exp(O_RV, 0, "R9");
    tick();
    exp(O_RV, 1, "R9"); exp(O_RVEC, 5, "R9");
    clrp('hFF);
    exp(O_PEND, 0, "R6");

    // late arrival during stacking (R11)
    irq_i = 'b0001; tick();
    exp(O_RV, 1, "R6"); exp(O_RVEC, 0, "R6");
    entry_start_i = 1; tick();
    exp(O_RV, 0, "R11"); exp(O_CAND, 0, "R11");
    setp('b1000);
    exp(O_LATE, 1, "R11");
    tick();
    exp(O_LATE, 0, "R11"); exp(O_CAND, 3, "R11");
    vec_fetch_i = 1; tick();
    exp(O_AVEC, 3, "R11"); exp(O_RANK, 2, "R11"); exp(O_PEND, 'h01, "R11");
    ret_i = 1; exp(O_TAIL, 1, "R11"); exp(O_RVEC, 0, "R11");
    tick();
    exp(O_AVEC, 0, "R10"); exp(O_RANK, 8, "R10"); exp(O_PEND, 0, "R10");
    ret_i = 1; tick();
    exp(O_AVAL, 0, "R12");
    tick(); tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule